// File: doc/BRIEF.md
# Transmit Watermark Request and Control-Data Ready Flags

This block produces the flow-control flags of a serial port. On the transmit side it computes the free space in a FIFO from the FIFO's occupancy and compares it with a programmable watermark. When the free space is strictly greater than the watermark, it raises a transfer request. A DMA controller may service that request one access at a time. Each acknowledged access drops the request for a cycle. The request then comes back by itself if the free space still exceeds the watermark.

On the receive side the block keeps one holding register for incoming control data and a ready flag that says whether the register holds valid data. New data overwrites the register even if the ready flag is already set. A software read clears the flag. Both flags can raise one shared interrupt line, and each has its own enable. A three-bit status word gathers the flags for a register read path outside this block.

Two small state machines do the work. The transmit machine has four states: `TX_OFF` (transmit disabled), `TX_IDLE` (free space at or below the watermark), `TX_REQ` (request raised) and `TX_HOLD` (the one blanking cycle after a DMA acknowledge). Its transitions are:
- *disable*: any state goes to `TX_OFF` when `tx_en` is low.
- *arm*: `TX_OFF`, `TX_IDLE` or `TX_HOLD` goes to `TX_REQ` when the condition holds, and to `TX_IDLE` otherwise.
- *drain*: `TX_REQ` goes to `TX_IDLE` when the condition fails.
- *serve*: `TX_REQ` goes to `TX_HOLD` on `dma_ack`.

The control-data machine has two states, `CD_EMPTY` and `CD_FULL`. Its transitions are:
- *capture*: a write, from either state, goes to `CD_FULL`.
- *consume*: a read without a write goes from `CD_FULL` to `CD_EMPTY`.
- *disable*: `rx_en` low goes to `CD_EMPTY`.

Top module: `sio_xfer_flags`

## Requirements
- R1: While `tx_en` is 1 and `tx_req` is 0, if the free space (FIFO_DEPTH minus `tx_level`) is strictly greater than `tx_wmark`, then `tx_req` is 1 after the next clock edge.
- R2: While `tx_en` is 1, if the free space is less than or equal to `tx_wmark`, then `tx_req` is 0 after the next clock edge.
- R3: A `dma_ack` sampled while `tx_req` is 1 makes `tx_req` 0 for exactly the next cycle. After that cycle it is 1 again if the free space still exceeds the watermark.
- R4: While `tx_en` is 0, `tx_req` is 0 from the next edge onward. A `dma_ack` sampled while `tx_req` is 0 has no effect.
- R5: A `ctl_wr` sampled with `rx_en` 1 loads `ctl_wdata` into `ctl_rdata` and sets `ctl_rdy` after the next edge.
- R6: A `ctl_rd` without `ctl_wr` clears `ctl_rdy` after the next edge and leaves `ctl_rdata` unchanged.
- R7: A `ctl_wr` while `ctl_rdy` is 1 overwrites `ctl_rdata` with the new value, and `ctl_rdy` stays 1.
- R8: When `ctl_rd` and `ctl_wr` arrive in the same cycle, the write wins: `ctl_rdy` is 1 and `ctl_rdata` holds the new value.
- R9: While `rx_en` is 0, `ctl_rdy` is 0 from the next edge onward and `ctl_wr` is ignored, so `ctl_rdata` stays unchanged.
- R10: `irq` equals (`tx_req` AND `ie_tx`) OR (`ctl_rdy` AND `ie_rdy`) in the same cycle, with no register in between.
- R11: `status` bit 2 is `tx_req`, bit 1 is reserved and always reads 0, and bit 0 is `ctl_rdy`.
- R12: While `rst_n` is 0, `tx_req`, `ctl_rdy`, `irq`, `status` and `ctl_rdata` are all 0.
- R13: A `tx_level` at or above FIFO_DEPTH counts as zero free space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| tx_level | input | LVL_W (5) | Entries occupied in the transmit FIFO |
| tx_wmark | input | WM_W (4) | Free-space watermark |
| dma_ack | input | 1 | One DMA access has serviced the request |
| ie_tx | input | 1 | Interrupt enable for the transmit request |
| rx_en | input | 1 | Receive enable |
| ctl_wr | input | 1 | New control data arrives |
| ctl_wdata | input | DATA_W (16) | Incoming control data |
| ctl_rd | input | 1 | Software reads the control-data register |
| ie_rdy | input | 1 | Interrupt enable for control-data ready |
| tx_req | output | 1 | Transmit transfer request |
| ctl_rdy | output | 1 | Control-data register holds valid data |
| ctl_rdata | output | DATA_W (16) | Held control data |
| irq | output | 1 | Shared interrupt |
| status | output | 3 | Status word: {tx_req, 0, ctl_rdy} |

## Verification
The bench probes the watermark boundary where the free space equals the watermark. A design that compares with greater-or-equal would raise the request one entry too early. It drives `dma_ack` while the condition persists and checks that the request drops for exactly one cycle. A design that never drops it, or that latches it low, fails there. It sends an occupancy above the FIFO depth to catch a free-space subtraction that wraps. It also presses a read and a write together to catch a design that lets the read win. Writes sent while receive is disabled expose a register that still captures data.

// File: rtl/sio_flags_pkg.sv
package sio_flags_pkg;

    typedef enum logic [1:0] {
        TX_OFF  = 2'd0,
        TX_IDLE = 2'd1,
        TX_REQ  = 2'd2,
        TX_HOLD = 2'd3
    } tx_state_e;

    typedef enum logic {
        CD_EMPTY = 1'b0,
        CD_FULL  = 1'b1
    } cd_state_e;

    // status word layout
    localparam int STAT_W      = 3;
    localparam int STAT_RDY    = 0;
    localparam int STAT_RSVD   = 1;
    localparam int STAT_TXREQ  = 2;

    // interrupt sources
    localparam int IRQ_SRC_TX  = 0;
    localparam int IRQ_SRC_RDY = 1;
    localparam int IRQ_N_SRC   = 2;

endpackage

// File: rtl/sio_tx_req_fsm.sv
module sio_tx_req_fsm
    import sio_flags_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int WM_W       = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [WM_W-1:0]  tx_wmark,
    input  logic             dma_ack,
    output logic             tx_req
);

    localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(FIFO_DEPTH);

    tx_state_e        state_q, state_d;
    logic [LVL_W-1:0] free_space;
    logic             above_wm;

    // free space, saturating at zero for an out-of-range occupancy
    always_comb begin
        if (tx_level >= DEPTH_V) begin
            free_space = '0;
        end else begin
            free_space = DEPTH_V - tx_level;
        end
        above_wm = free_space > LVL_W'(tx_wmark);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!tx_en) begin
            state_d = TX_OFF;                               // disable
        end else begin
            unique case (state_q)
                TX_OFF, TX_IDLE, TX_HOLD: begin
                    state_d = above_wm ? TX_REQ : TX_IDLE;  // arm
                end
                TX_REQ: begin
                    if (dma_ack) begin
                        state_d = TX_HOLD;                  // serve
                    end else if (!above_wm) begin
                        state_d = TX_IDLE;                  // drain
                    end
                end
                default: state_d = TX_OFF;
            endcase
        end
    end

    always_comb begin
        tx_req = (state_q == TX_REQ);
    end

endmodule

// File: rtl/sio_ctl_hold_fsm.sv
module sio_ctl_hold_fsm
    import sio_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ctl_rd,
    output logic              ctl_rdy,
    output logic [DATA_W-1:0] ctl_rdata
);

    cd_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              capture;

    always_comb begin
        capture = rx_en && ctl_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= ctl_wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!rx_en) begin
            state_d = CD_EMPTY;                 // disable
        end else begin
            unique case (state_q)
                CD_EMPTY: begin
                    if (ctl_wr) state_d = CD_FULL;          // capture
                end
                CD_FULL: begin
                    if (ctl_wr)      state_d = CD_FULL;     // capture wins
                    else if (ctl_rd) state_d = CD_EMPTY;    // consume
                end
                default: state_d = CD_EMPTY;
            endcase
        end
    end

    always_comb begin
        ctl_rdy   = (state_q == CD_FULL);
        ctl_rdata = data_q;
    end

endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] enables,
    output logic             irq
);

    logic [N_SRC-1:0] gated;

    for (genvar i = 0; i < N_SRC; i++) begin : g_gate
        assign gated[i] = flags[i] & enables[i];
    end

    always_comb begin
        irq = |gated;
    end

endmodule

// File: rtl/sio_xfer_flags.sv
module sio_xfer_flags
    import sio_flags_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int WM_W       = 4,
    parameter int DATA_W     = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [WM_W-1:0]   tx_wmark,
    input  logic              dma_ack,
    input  logic              ie_tx,
    input  logic              rx_en,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              ctl_rd,
    input  logic              ie_rdy,
    output logic              tx_req,
    output logic              ctl_rdy,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              irq,
    output logic [STAT_W-1:0] status
);

    logic [IRQ_N_SRC-1:0] src_flags;
    logic [IRQ_N_SRC-1:0] src_en;

    sio_tx_req_fsm #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .WM_W       (WM_W),
        .LVL_W      (LVL_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tx_level (tx_level),
        .tx_wmark (tx_wmark),
        .dma_ack  (dma_ack),
        .tx_req   (tx_req)
    );

    sio_ctl_hold_fsm #(
        .DATA_W (DATA_W)
    ) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_rd    (ctl_rd),
        .ctl_rdy   (ctl_rdy),
        .ctl_rdata (ctl_rdata)
    );

    always_comb begin
        src_flags              = '0;
        src_en                 = '0;
        src_flags[IRQ_SRC_TX]  = tx_req;
        src_flags[IRQ_SRC_RDY] = ctl_rdy;
        src_en[IRQ_SRC_TX]     = ie_tx;
        src_en[IRQ_SRC_RDY]    = ie_rdy;
    end

    sio_irq_merge #(
        .N_SRC (IRQ_N_SRC)
    ) u_irq (
        .flags   (src_flags),
        .enables (src_en),
        .irq     (irq)
    );

    always_comb begin
        status             = '0;
        status[STAT_TXREQ] = tx_req;
        status[STAT_RSVD]  = 1'b0;
        status[STAT_RDY]   = ctl_rdy;
    end

endmodule

// File: rtl/sio_xfer_flags_chk.sv
module sio_xfer_flags_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int WM_W       = 4,
    parameter int DATA_W     = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic [LVL_W-1:0]  tx_level,
    input logic [WM_W-1:0]   tx_wmark,
    input logic              dma_ack,
    input logic              ie_tx,
    input logic              rx_en,
    input logic              ctl_wr,
    input logic [DATA_W-1:0] ctl_wdata,
    input logic              ctl_rd,
    input logic              ie_rdy,
    input logic              tx_req,
    input logic              ctl_rdy,
    input logic [DATA_W-1:0] ctl_rdata,
    input logic              irq
);

    logic [LVL_W:0] room;
    logic           over;

    always_comb begin
        room = (int'(tx_level) >= FIFO_DEPTH) ? '0
             : (LVL_W+1)'(FIFO_DEPTH - int'(tx_level));
        over = int'(room) > int'(tx_wmark);
    end

    assert_raise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && over && !tx_req) |=> tx_req);

    assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !over) |=> !tx_req);

    assert_dma_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && dma_ack) |=> !tx_req);

    assert_tx_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_req);

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && ctl_wr) |=> (ctl_rdy && ctl_rdata == $past(ctl_wdata)));

    assert_consume_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && ctl_rd && !ctl_wr) |=> (!ctl_rdy && $stable(ctl_rdata)));

    assert_rx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!ctl_rdy && $stable(ctl_rdata)));

    assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((tx_req && ie_tx) || (ctl_rdy && ie_rdy)));

endmodule

bind sio_xfer_flags sio_xfer_flags_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .WM_W       (WM_W),
    .DATA_W     (DATA_W),
    .LVL_W      (LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .tx_level  (tx_level),
    .tx_wmark  (tx_wmark),
    .dma_ack   (dma_ack),
    .ie_tx     (ie_tx),
    .rx_en     (rx_en),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rd    (ctl_rd),
    .ie_rdy    (ie_rdy),
    .tx_req    (tx_req),
    .ctl_rdy   (ctl_rdy),
    .ctl_rdata (ctl_rdata),
    .irq       (irq)
);

// File: tb/sim_sio_xfer_flags.sv
`timescale 1ns/1ps
module sim_sio_xfer_flags;

    localparam int FIFO_DEPTH = 16;
    localparam int WM_W       = 4;
    localparam int DATA_W     = 16;
    localparam int LVL_W      = 5;
    localparam int N_VEC      = 17;

    // vector: {level[11:7], wmark[6:3], tx_en[2], dma_ack[1], exp_req[0]}
    localparam logic [11:0] TXV [N_VEC] = '{
        {5'd0,  4'd0,  1'b0, 1'b0, 1'b0},   // disabled
        {5'd0,  4'd3,  1'b1, 1'b0, 1'b1},   // R1 free 16 > 3
        {5'd12, 4'd3,  1'b1, 1'b0, 1'b1},   // R1 free 4 > 3
        {5'd13, 4'd3,  1'b1, 1'b0, 1'b0},   // R2 free 3 == 3
        {5'd13, 4'd2,  1'b1, 1'b0, 1'b1},   // R1 free 3 > 2
        {5'd13, 4'd2,  1'b1, 1'b1, 1'b0},   // R3 ack drops
        {5'd13, 4'd2,  1'b1, 1'b0, 1'b1},   // R3 re-raise
        {5'd14, 4'd2,  1'b1, 1'b1, 1'b0},   // R3 ack drops
        {5'd14, 4'd2,  1'b1, 1'b0, 1'b0},   // R2 free 2 == 2
        {5'd14, 4'd2,  1'b1, 1'b1, 1'b0},   // R4 ack while low ignored
        {5'd16, 4'd0,  1'b1, 1'b0, 1'b0},   // R2 full FIFO
        {5'd20, 4'd0,  1'b1, 1'b0, 1'b0},   // R13 over-range level
        {5'd15, 4'd0,  1'b1, 1'b0, 1'b1},   // R1 free 1 > 0
        {5'd0,  4'd0,  1'b0, 1'b0, 1'b0},   // R4 disable
        {5'd0,  4'd0,  1'b0, 1'b1, 1'b0},   // R4 disabled, ack
        {5'd0,  4'd15, 1'b1, 1'b0, 1'b1},   // R1 free 16 > 15
        {5'd1,  4'd15, 1'b1, 1'b0, 1'b0}    // R2 free 15 == 15
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_en = 1'b0;
    logic [LVL_W-1:0]  tx_level = '0;
    logic [WM_W-1:0]   tx_wmark = '0;
    logic              dma_ack = 1'b0;
    logic              ie_tx = 1'b0;
    logic              rx_en = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [DATA_W-1:0] ctl_wdata = '0;
    logic              ctl_rd = 1'b0;
    logic              ie_rdy = 1'b0;
    logic              tx_req;
    logic              ctl_rdy;
    logic [DATA_W-1:0] ctl_rdata;
    logic              irq;
    logic [2:0]        status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sio_xfer_flags #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .WM_W       (WM_W),
        .DATA_W     (DATA_W),
        .LVL_W      (LVL_W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .tx_level  (tx_level),
        .tx_wmark  (tx_wmark),
        .dma_ack   (dma_ack),
        .ie_tx     (ie_tx),
        .rx_en     (rx_en),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_rd    (ctl_rd),
        .ie_rdy    (ie_rdy),
        .tx_req    (tx_req),
        .ctl_rdy   (ctl_rdy),
        .ctl_rdata (ctl_rdata),
        .irq       (irq),
        .status    (status)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // reset state, R12
        repeat (2) step();
        check("R12 tx_req", 32'(tx_req), 0);
        check("R12 ctl_rdy", 32'(ctl_rdy), 0);
        check("R12 ctl_rdata", 32'(ctl_rdata), 0);
        check("R12 irq", 32'(irq), 0);
        check("R12 status", 32'(status), 0);
        rst_n = 1'b1;
        ie_tx = 1'b1;

        // transmit vector table, R1 R2 R3 R4 R13 and irq R10
        for (int i = 0; i < N_VEC; i++) begin
            tx_level = TXV[i][11:7];
            tx_wmark = TXV[i][6:3];
            tx_en    = TXV[i][2];
            dma_ack  = TXV[i][1];
            step();
            check($sformatf("R1-table vec %0d tx_req", i), 32'(tx_req), 32'(TXV[i][0]));
            check($sformatf("R10 vec %0d irq", i), 32'(irq), 32'(TXV[i][0]));
        end
        dma_ack = 1'b0;

        // R10: request high but interrupt disabled
        tx_en = 1'b1; tx_level = '0; tx_wmark = '0;
        step();
        check("R1 tx_req", 32'(tx_req), 1);
        ie_tx = 1'b0;
        #1;
        check("R10 irq masked", 32'(irq), 0);

        // R5 capture
        rx_en = 1'b1; ctl_wr = 1'b1; ctl_wdata = 16'h1234;
        step();
        ctl_wr = 1'b0;
        check("R5 ctl_rdy", 32'(ctl_rdy), 1);
        check("R5 ctl_rdata", 32'(ctl_rdata), 32'h1234);
        check("R11 status both", 32'(status), 32'b101);

        // R7 overwrite while full
        ctl_wr = 1'b1; ctl_wdata = 16'hBEEF;
        step();
        ctl_wr = 1'b0;
        check("R7 ctl_rdy", 32'(ctl_rdy), 1);
        check("R7 ctl_rdata", 32'(ctl_rdata), 32'hBEEF);

        // R10 ready interrupt
        ie_rdy = 1'b1;
        #1;
        check("R10 irq rdy", 32'(irq), 1);

        // R6 read clears
        ctl_rd = 1'b1;
        step();
        ctl_rd = 1'b0;
        check("R6 ctl_rdy", 32'(ctl_rdy), 0);
        check("R6 ctl_rdata", 32'(ctl_rdata), 32'hBEEF);
        check("R10 irq after read", 32'(irq), 0);

        // R6 read when empty stays empty
        ctl_rd = 1'b1;
        step();
        ctl_rd = 1'b0;
        check("R6 empty read", 32'(ctl_rdy), 0);

        // R8 read and write together
        ctl_wr = 1'b1; ctl_wdata = 16'h1111;
        step();
        ctl_wr = 1'b1; ctl_rd = 1'b1; ctl_wdata = 16'h2222;
        step();
        ctl_wr = 1'b0; ctl_rd = 1'b0;
        check("R8 ctl_rdy", 32'(ctl_rdy), 1);
        check("R8 ctl_rdata", 32'(ctl_rdata), 32'h2222);

        // R9 disable clears flag, writes ignored
        rx_en = 1'b0;
        step();
        check("R9 ctl_rdy off", 32'(ctl_rdy), 0);
        ctl_wr = 1'b1; ctl_wdata = 16'h7777;
        step();
        ctl_wr = 1'b0;
        check("R9 ctl_rdy still off", 32'(ctl_rdy), 0);
        check("R9 ctl_rdata kept", 32'(ctl_rdata), 32'h2222);
        check("R11 status", 32'(status), 32'b100);

        // R12 asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        check("R12 tx_req async", 32'(tx_req), 0);
        check("R12 ctl_rdata async", 32'(ctl_rdata), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule